// File: doc/BRIEF.md
# Receive Buffer Descriptor Queue

This block keeps the list of empty host buffers that a DMA network interface may fill with received frames. The host describes a buffer in its address and byte-count registers, then issues a "supply buffer" command. The block forms a bus address from those registers and checks that the buffer is usable. A usable buffer is appended to a first-in, first-out queue. Every supply command is answered one cycle later with a done pulse and a status code.

The receive DMA engine takes the oldest descriptor when a frame arrives. It holds that descriptor for the length of the transfer. It then reports completion with the frame length. The block raises a sticky receive-done flag and records whether the frame fitted in the buffer. A separate flush command throws away every descriptor still waiting, but a transfer already in progress still finishes.

The address width depends on a strap. With the strap high, six extension bits sit above the 16-bit bus address, giving 22 bits. With the strap low, two extended bits from the control register are used instead, giving 18 bits, and the upper four bits are zero. The `rst_n` input is asynchronous active-low and must be released in step with `clk`.

Top module: `rx_desc_queue`

## Requirements
- R1: A command with function code octal 40 (`cmd_func` = 6'o40) and a well-formed buffer appends one descriptor. `cmd_done` pulses for exactly one cycle, in the cycle after `cmd_valid`, with `cmd_status` = 0.
- R2: The descriptor address is {`cmd_ext`, `cmd_bar`} when `ext_en` = 1. It is {4'b0, `cmd_xm`, `cmd_bar`} when `ext_en` = 0. The descriptor count equals `cmd_bcr`.
- R3: A supplied buffer is malformed if its address is odd, or its byte count is zero or odd. A malformed buffer is answered with `cmd_status` = 10 (octal 12) and is not queued. The alignment check takes priority over the full check.
- R4: The queue holds up to 16 descriptors. A well-formed supply that arrives while 16 are queued is answered with `cmd_status` = 15 and leaves the queue unchanged.
- R5: Descriptors are handed out in the order they were supplied. `desc_addr` and `desc_count` show the oldest waiting descriptor while `desc_avail` = 1.
- R6: Function code octal 60 empties all waiting descriptors and is answered with `cmd_status` = 0. A descriptor already taken by the engine still completes normally.
- R7: When the engine completes a held descriptor (`cpl_valid` = 1), `rx_done` is 1 from the next cycle. It stays 1 until `done_clr` is pulsed. `rx_status` = 0 when `cpl_len` is no larger than the buffer's byte count.
- R8: A completion with `cpl_len` greater than the held buffer's byte count sets `rx_status` = 5 (octal 05).
- R9: Function codes other than octal 40 and octal 60 give no `cmd_done` pulse and do not change the queue.
- R10: After reset the queue is empty, `desc_avail`, `cmd_done` and `rx_done` are 0, and no descriptor is held.
- R11: The engine holds at most one descriptor at a time. `desc_avail` is 0 while a descriptor is held, even if entries are waiting. `desc_pop` is accepted only while `desc_avail` = 1. A completion with no held descriptor is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_en | input | 1 | Strap: 1 selects the 22-bit address from the extension bits |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_func | input | 6 | Command function code |
| cmd_bar | input | 16 | Low 16 bits of the buffer bus address |
| cmd_bcr | input | 16 | Buffer byte count |
| cmd_ext | input | 6 | Address bits 21..16 when the strap is set |
| cmd_xm | input | 2 | Address bits 17..16 when the strap is clear |
| cmd_done | output | 1 | One-cycle command-done pulse |
| cmd_status | output | 4 | Status of the last answered command |
| desc_avail | output | 1 | A waiting descriptor may be taken |
| desc_addr | output | 22 | Address of the oldest waiting descriptor |
| desc_count | output | 16 | Byte count of the oldest waiting descriptor |
| desc_pop | input | 1 | Engine takes the oldest descriptor |
| cpl_valid | input | 1 | Engine finished the held descriptor |
| cpl_len | input | 16 | Length of the received frame |
| done_clr | input | 1 | Clears the receive-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_status | output | 4 | Status of the last completed receive |

## Verification
Some properties are checked by assertions on every cycle:
- the occupancy never exceeds the depth and no write lands in a full queue;
- a flush leaves the queue empty;
- the first entry written into an empty queue appears at the head;
- a done pulse always follows a command;
- `rx_done` only rises after a completion of a held descriptor;
- a descriptor is never taken while another is held.

Other behaviour can only be shown by the bench's scenarios:
- address formation under both strap settings;
- the exact status codes for malformed, oversize and full cases;
- strict ordering across a full queue;
- a flush that spares the in-flight transfer;
- the silence on unrelated function codes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int BAR_W  = 16;
  parameter int EXT_W  = 6;
  parameter int XM_W   = 2;
  parameter int CNT_W  = 16;
  parameter int FUNC_W = 6;
  parameter int STAT_W = 4;
  localparam int ADDR_W = BAR_W + EXT_W;

  localparam logic [FUNC_W-1:0] FN_SUPPLY = 6'o40;
  localparam logic [FUNC_W-1:0] FN_FLUSH  = 6'o60;

  localparam logic [STAT_W-1:0] ST_OK    = 4'o00;
  localparam logic [STAT_W-1:0] ST_SIZE  = 4'o05;
  localparam logic [STAT_W-1:0] ST_ALIGN = 4'o12;
  localparam logic [STAT_W-1:0] ST_FULL  = 4'o17;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  count;
  } desc_t;
endpackage

// File: rtl/rxq_addr_form.sv
module rxq_addr_form
  import rxq_pkg::*;
(
  input  logic             ext_en,
  input  logic [BAR_W-1:0] bar,
  input  logic [CNT_W-1:0] bcr,
  input  logic [EXT_W-1:0] ext,
  input  logic [XM_W-1:0]  xm,
  output desc_t            desc,
  output logic             well_formed
);
  localparam int PAD_W = EXT_W - XM_W;

  always_comb begin
    desc.count = bcr;
    if (ext_en) desc.addr = {ext, bar};
    else        desc.addr = {{PAD_W{1'b0}}, xm, bar};
    well_formed = !desc.addr[0] && (bcr != '0) && !bcr[0];
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  desc_t push_desc,
  input  logic  pop,
  input  logic  flush,
  output desc_t head,
  output logic  empty,
  output logic  full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] DEPTH_C = OCC_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

  desc_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [OCC_W-1:0] occ, occ_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    occ_n    = occ;
    if (push) wr_ptr_n = bump(wr_ptr);
    if (pop)  rd_ptr_n = bump(rd_ptr);
    if (push && !pop)      occ_n = occ + 1'b1;
    else if (!push && pop) occ_n = occ - 1'b1;
    if (flush) begin
      rd_ptr_n = wr_ptr_n;
      occ_n    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      occ    <= occ_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_desc;
  end

  assign head  = mem[rd_ptr];
  assign empty = (occ == '0);
  assign full  = (occ == DEPTH_C);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop) && (occ <= DEPTH_C));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !push) |=> empty);
  // R5
  first_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && empty && !flush) |=> (head == $past(push_desc)));
endmodule

// File: rtl/rxq_cmd_ctrl.sv
module rxq_cmd_ctrl
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic              well_formed,
  input  logic              full,
  output logic              push,
  output logic              flush,
  output logic              cmd_done,
  output logic [STAT_W-1:0] cmd_status
);
  logic              is_supply, is_flush;
  logic              done_n;
  logic [STAT_W-1:0] status_n;

  always_comb begin
    is_supply = cmd_valid && (cmd_func == FN_SUPPLY);
    is_flush  = cmd_valid && (cmd_func == FN_FLUSH);
    push      = is_supply && well_formed && !full;
    flush     = is_flush;
    done_n    = is_supply || is_flush;
    status_n  = cmd_status;
    if (is_flush)                      status_n = ST_OK;
    else if (is_supply && !well_formed) status_n = ST_ALIGN;
    else if (is_supply && full)         status_n = ST_FULL;
    else if (is_supply)                 status_n = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done   <= 1'b0;
      cmd_status <= ST_OK;
    end else begin
      cmd_done   <= done_n;
      cmd_status <= status_n;
    end
  end

  // R1
  done_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(cmd_valid));
  // R9
  foreign_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_func != FN_SUPPLY && cmd_func != FN_FLUSH) |=> !cmd_done);
endmodule

// File: rtl/rxq_cpl.sv
module rxq_cpl
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CNT_W-1:0]  take_count,
  input  logic              cpl_valid,
  input  logic [CNT_W-1:0]  cpl_len,
  input  logic              done_clr,
  output logic              busy,
  output logic              rx_done,
  output logic [STAT_W-1:0] rx_status
);
  logic              busy_n, done_n, fire;
  logic [CNT_W-1:0]  held, held_n;
  logic [STAT_W-1:0] status_n;

  always_comb begin
    fire     = cpl_valid && busy;
    busy_n   = busy;
    held_n   = held;
    done_n   = rx_done;
    status_n = rx_status;
    if (take) begin
      busy_n = 1'b1;
      held_n = take_count;
    end
    if (fire) begin
      busy_n   = 1'b0;
      status_n = (cpl_len > held) ? ST_SIZE : ST_OK;
    end
    if (fire)          done_n = 1'b1;
    else if (done_clr) done_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held      <= '0;
      rx_done   <= 1'b0;
      rx_status <= ST_OK;
    end else begin
      busy      <= busy_n;
      held      <= held_n;
      rx_done   <= done_n;
      rx_status <= status_n;
    end
  end

  // R11
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !busy);
  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(cpl_valid && busy));
endmodule

// File: rtl/rx_desc_queue.sv
module rx_desc_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              cmd_valid,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [BAR_W-1:0]  cmd_bar,
  input  logic [CNT_W-1:0]  cmd_bcr,
  input  logic [EXT_W-1:0]  cmd_ext,
  input  logic [XM_W-1:0]   cmd_xm,
  output logic              cmd_done,
  output logic [STAT_W-1:0] cmd_status,
  output logic              desc_avail,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [CNT_W-1:0]  desc_count,
  input  logic              desc_pop,
  input  logic              cpl_valid,
  input  logic [CNT_W-1:0]  cpl_len,
  input  logic              done_clr,
  output logic              rx_done,
  output logic [STAT_W-1:0] rx_status
);
  desc_t new_desc, head;
  logic  well_formed, push, flush, empty, full, busy, take;

  rxq_addr_form u_form (
    .ext_en      (ext_en),
    .bar         (cmd_bar),
    .bcr         (cmd_bcr),
    .ext         (cmd_ext),
    .xm          (cmd_xm),
    .desc        (new_desc),
    .well_formed (well_formed)
  );

  rxq_cmd_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_func    (cmd_func),
    .well_formed (well_formed),
    .full        (full),
    .push        (push),
    .flush       (flush),
    .cmd_done    (cmd_done),
    .cmd_status  (cmd_status)
  );

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_desc (new_desc),
    .pop       (take),
    .flush     (flush),
    .head      (head),
    .empty     (empty),
    .full      (full)
  );

  rxq_cpl u_cpl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_count (head.count),
    .cpl_valid  (cpl_valid),
    .cpl_len    (cpl_len),
    .done_clr   (done_clr),
    .busy       (busy),
    .rx_done    (rx_done),
    .rx_status  (rx_status)
  );

  assign desc_avail = !empty && !busy;
  assign take       = desc_pop && desc_avail;
  assign desc_addr  = head.addr;
  assign desc_count = head.count;

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!desc_avail && !rx_done && !cmd_done));
endmodule

// File: tb/tb_rx_desc_queue.sv
module tb_rx_desc_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_func = '0;
  logic [15:0] cmd_bar = '0;
  logic [15:0] cmd_bcr = '0;
  logic [5:0]  cmd_ext = '0;
  logic [1:0]  cmd_xm = '0;
  logic        cmd_done;
  logic [3:0]  cmd_status;
  logic        desc_avail;
  logic [21:0] desc_addr;
  logic [15:0] desc_count;
  logic        desc_pop = 1'b0;
  logic        cpl_valid = 1'b0;
  logic [15:0] cpl_len = '0;
  logic        done_clr = 1'b0;
  logic        rx_done;
  logic [3:0]  rx_status;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_desc_queue dut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .cmd_valid(cmd_valid),
    .cmd_func(cmd_func), .cmd_bar(cmd_bar), .cmd_bcr(cmd_bcr),
    .cmd_ext(cmd_ext), .cmd_xm(cmd_xm), .cmd_done(cmd_done),
    .cmd_status(cmd_status), .desc_avail(desc_avail), .desc_addr(desc_addr),
    .desc_count(desc_count), .desc_pop(desc_pop), .cpl_valid(cpl_valid),
    .cpl_len(cpl_len), .done_clr(done_clr), .rx_done(rx_done),
    .rx_status(rx_status)
  );

  typedef struct packed {
    logic [15:0] bar;
    logic [15:0] bcr;
    logic [5:0]  ext;
    logic [1:0]  xm;
    logic        en;
    logic [3:0]  st;
    logic [21:0] addr;
    logic [15:0] clen;
    logic [3:0]  rst;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{16'h1000, 16'd64,     6'h2A, 2'd1, 1'b1, 4'd0,  22'h2A1000, 16'd64,   4'd0},
    '{16'h2002, 16'd128,    6'h3F, 2'd2, 1'b0, 4'd0,  22'h022002, 16'd129,  4'd5},
    '{16'h0001, 16'd64,     6'h00, 2'd0, 1'b1, 4'd10, 22'h000000, 16'd0,    4'd0},
    '{16'h0100, 16'd0,      6'h00, 2'd0, 1'b1, 4'd10, 22'h000000, 16'd0,    4'd0},
    '{16'h0100, 16'd33,     6'h00, 2'd0, 1'b1, 4'd10, 22'h000000, 16'd0,    4'd0},
    '{16'hFFFE, 16'hFFFE,   6'h01, 2'd3, 1'b1, 4'd0,  22'h01FFFE, 16'd1000, 4'd0},
    '{16'h4000, 16'd2,      6'h3F, 2'd3, 1'b0, 4'd0,  22'h034000, 16'd3,    4'd5}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic issue(input logic [5:0] f, input logic [15:0] bar, input logic [15:0] bcr,
                       input logic [5:0] ext, input logic [1:0] xm,
                       output logic d, output logic [3:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_bar = bar; cmd_bcr = bcr; cmd_ext = ext; cmd_xm = xm;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = cmd_done; s = cmd_status;
  endtask

  task automatic take(output logic av, output logic [21:0] a, output logic [15:0] c);
    @(negedge clk);
    av = desc_avail; a = desc_addr; c = desc_count;
    desc_pop = 1'b1;
    @(negedge clk);
    desc_pop = 1'b0;
  endtask

  task automatic complete(input logic [15:0] len, output logic d, output logic [3:0] s);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_len = len;
    @(negedge clk);
    cpl_valid = 1'b0;
    d = rx_done; s = rx_status;
  endtask

  task automatic clear_done;
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic d, av;
    logic [3:0] s;
    logic [21:0] a;
    logic [15:0] c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!desc_avail && !rx_done && !cmd_done, "R10", {desc_avail, rx_done, cmd_done}, 0);

    // R9 foreign function code: no done pulse, queue stays empty
    issue(6'o51, 16'h0010, 16'd8, 6'h0, 2'd0, d, s);
    chk(!d, "R9 done", d, 0);
    @(negedge clk);
    chk(!desc_avail, "R9 queue", desc_avail, 0);

    // vector table: supply commands (R1 R2 R3)
    for (int i = 0; i < NV; i++) begin
      ext_en = VEC[i].en;
      issue(6'o40, VEC[i].bar, VEC[i].bcr, VEC[i].ext, VEC[i].xm, d, s);
      chk(d, "R1 done", d, 1);
      chk(s == VEC[i].st, (VEC[i].st == 0) ? "R1 status" : "R3 status", s, VEC[i].st);
    end
    // drain accepted ones in order (R2 R5 R7 R8)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].st == 4'd0) begin
        take(av, a, c);
        chk(av, "R5 avail", av, 1);
        chk(a == VEC[i].addr, "R2 addr", a, VEC[i].addr);
        chk(c == VEC[i].bcr, "R2 count", c, VEC[i].bcr);
        complete(VEC[i].clen, d, s);
        chk(d, "R7 done", d, 1);
        chk(s == VEC[i].rst, (VEC[i].rst == 0) ? "R7 status" : "R8 status", s, VEC[i].rst);
        clear_done();
      end
    end
    @(negedge clk);
    chk(!desc_avail, "R3 not queued", desc_avail, 0);

    // R4 fill to 16, then one more
    ext_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      issue(6'o40, 16'(i * 4), 16'(i * 2 + 2), 6'h0, 2'd0, d, s);
      chk(s == 4'd0, "R4 fill", s, 0);
    end
    issue(6'o40, 16'h0800, 16'd8, 6'h0, 2'd0, d, s);
    chk(d && s == 4'd15, "R4 full", {d, s}, {1'b1, 4'd15});
    for (int i = 0; i < 16; i++) begin
      take(av, a, c);
      chk(av && a == 22'(i * 4) && c == 16'(i * 2 + 2), "R5 order", a, 22'(i * 4));
      complete(16'd1, d, s);
    end
    @(negedge clk);
    chk(!desc_avail, "R4 unchanged", desc_avail, 0);
    clear_done();

    // R6 / R11 flush while one descriptor is held
    issue(6'o40, 16'h0010, 16'd8, 6'h0, 2'd0, d, s);
    issue(6'o40, 16'h0020, 16'd8, 6'h0, 2'd0, d, s);
    issue(6'o40, 16'h0030, 16'd8, 6'h0, 2'd0, d, s);
    take(av, a, c);
    chk(a == 22'h10, "R5 head", a, 22'h10);
    chk(!desc_avail, "R11 held blocks", desc_avail, 0);
    issue(6'o60, 16'h0, 16'h0, 6'h0, 2'd0, d, s);
    chk(d && s == 4'd0, "R6 flush status", {d, s}, {1'b1, 4'd0});
    complete(16'd8, d, s);
    chk(d && s == 4'd0, "R6 held completes", {d, s}, {1'b1, 4'd0});
    chk(!desc_avail, "R6 emptied", desc_avail, 0);
    @(negedge clk);
    chk(rx_done, "R7 sticky", rx_done, 1);
    clear_done();
    chk(!rx_done, "R7 clear", rx_done, 0);
    complete(16'd4, d, s);
    chk(!d, "R11 stray completion", d, 0);

    summary();
  end
endmodule